// File: doc/BRIEF.md
# Configurable Shift and Rotate Unit

This unit moves the bits of an integer operand left or right, either as an arithmetic shift or as a circular rotation, entirely in combinational logic. A single signed count carries both the distance and the direction: a positive count moves bits toward the most significant end, and a negative count moves them toward the least significant end by the count's magnitude. A mode input chooses between discarding bits that fall off an end and feeding them back in at the opposite end.

The operand is always presented on a 32-bit port, but the caller selects at run time whether it holds an 8-, 16- or 32-bit value and whether that value is signed. Narrow types are processed only within their own low lane. The result is then widened back to 32 bits with copies of the lane's top bit for signed types, or with zeros for unsigned types. A count whose magnitude does not fit inside the selected lane raises an error flag and produces a zero result. The unit has no clock and holds no state, so it drops into any datapath stage between registers.

Top module: `shift_rotate_unit`

## Requirements
- R1: A positive count moves the operand toward the most significant bit, and a negative count moves it toward the least significant bit, by the absolute value of the count. The count is a 6-bit two's-complement value.
- R2: With `rotate_i`=0 and a positive count, the vacated low bits become zero and bits pushed past the top of the lane are lost.
- R3: With `rotate_i`=0, a negative count and a signed type, the vacated high bits of the lane take the value of the lane's top bit before the shift.
- R4: With `rotate_i`=0, a negative count and an unsigned type, the vacated high bits of the lane become zero.
- R5: With `rotate_i`=1, bits that leave one end of the lane come back in at the other end, in both directions. The number of set bits in the lane does not change.
- R6: A count of zero returns the lane value unchanged, extended as in R8, in both modes, with `range_err_o`=0.
- R7: `dtype_i[1:0]` selects the lane width: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits, and 3 is invalid. An invalid code raises `range_err_o` and forces the result to zero. `dtype_i[2]`=1 marks the type as signed. For 8- and 16-bit lanes, operand bits above the lane have no effect on the result.
- R8: For 8- and 16-bit lanes, the result bits above the lane are copies of the result lane's top bit for signed types, and zero for unsigned types.
- R9: When the magnitude of the count is equal to or greater than the lane width, `range_err_o`=1 and `result_o`=0. When it is smaller, `range_err_o`=0.
- R10: The outputs depend only on the present inputs. No clock or state is involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Operand word. Narrow types use its low lane. |
| dtype_i | input | 3 | Bit 2 selects signed. Bits 1:0 select the lane width (0: 8, 1: 16, 2: 32, 3: invalid). |
| count_i | input | 6 | Signed count. The sign sets the direction and the magnitude sets the distance. |
| rotate_i | input | 1 | 0 selects an arithmetic shift, 1 selects a circular rotation. |
| result_o | output | 32 | Shifted or rotated value, extended to 32 bits. |
| range_err_o | output | 1 | The count magnitude does not fit the lane, or the width code is invalid. |

## Verification
The hardest cases to reach from the ports are the exact edges of the count range for each lane: a magnitude of width minus one must succeed, while a magnitude equal to the width must fail. The most negative count, -32, matters as well, because its magnitude cannot be represented as a positive value of the same width. Uniform random counts seldom land on these few values for a given width code. Directed cases therefore cover them for all three widths and both signs. Random stimulus also forces the count into a band around each lane's boundary in a fixed share of iterations.

// File: rtl/shr_pkg.sv
package shr_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = $clog2(DATA_W) + 1;

  typedef enum logic [1:0] {
    LANE_8   = 2'd0,
    LANE_16  = 2'd1,
    LANE_32  = 2'd2,
    LANE_BAD = 2'd3
  } lane_sel_e;

  typedef struct packed {
    logic              to_left;
    logic              is_signed;
    logic [CNT_W-1:0]  magnitude;
    lane_sel_e         lane;
    logic              range_err;
  } shr_ctrl_t;

endpackage

// File: rtl/shr_decode.sv
module shr_decode
  import shr_pkg::*;
#(
  parameter int unsigned OP_W  = 32,
  parameter int unsigned CNT_W = $clog2(OP_W) + 1
) (
  input  logic [2:0]        dtype_i,
  input  logic [CNT_W-1:0]  count_i,
  output shr_ctrl_t         ctrl_o
);

  localparam int unsigned NARROW_W = OP_W / 4;
  localparam int unsigned MID_W    = OP_W / 2;

  logic [CNT_W-1:0] mag;
  logic [CNT_W:0]   lane_width;
  lane_sel_e        lane;

  always_comb begin
    lane = lane_sel_e'(dtype_i[1:0]);
    if (count_i[CNT_W-1]) begin
      mag = (~count_i) + 1'b1;
    end else begin
      mag = count_i;
    end
    unique case (lane)
      LANE_8:  lane_width = (CNT_W+1)'(NARROW_W);
      LANE_16: lane_width = (CNT_W+1)'(MID_W);
      LANE_32: lane_width = (CNT_W+1)'(OP_W);
      default: lane_width = '0;
    endcase
  end

  always_comb begin
    ctrl_o.to_left   = ~count_i[CNT_W-1];
    ctrl_o.is_signed = dtype_i[2];
    ctrl_o.magnitude = mag;
    ctrl_o.lane      = lane;
    ctrl_o.range_err = (lane == LANE_BAD) || ({1'b0, mag} >= lane_width);
  end

endmodule

// File: rtl/shr_lane.sv
module shr_lane #(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned AMT_W = $clog2(LANE_W),
  localparam int unsigned STAGES = AMT_W
) (
  input  logic [LANE_W-1:0] lane_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              to_left_i,
  input  logic              rotate_i,
  input  logic              is_signed_i,
  output logic [LANE_W-1:0] lane_o
);

  logic fill_bit;

  always_comb begin
    fill_bit = is_signed_i & lane_i[LANE_W-1];
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int unsigned SH = 1 << k;
    logic [LANE_W-1:0] din;
    logic [LANE_W-1:0] moved;
    logic [LANE_W-1:0] dout;

    if (k == 0) begin : g_first
      assign din = lane_i;
    end else begin : g_next
      assign din = g_stage[k-1].dout;
    end

    always_comb begin
      if (to_left_i) begin
        if (rotate_i) begin
          moved = {din[LANE_W-1-SH:0], din[LANE_W-1:LANE_W-SH]};
        end else begin
          moved = {din[LANE_W-1-SH:0], {SH{1'b0}}};
        end
      end else begin
        if (rotate_i) begin
          moved = {din[SH-1:0], din[LANE_W-1:SH]};
        end else begin
          moved = {{SH{fill_bit}}, din[LANE_W-1:SH]};
        end
      end
      dout = amt_i[k] ? moved : din;
    end
  end

  assign lane_o = g_stage[STAGES-1].dout;

endmodule

// File: rtl/shr_extend.sv
module shr_extend
  import shr_pkg::*;
#(
  parameter int unsigned OP_W = 32,
  localparam int unsigned NARROW_W = OP_W / 4,
  localparam int unsigned MID_W    = OP_W / 2
) (
  input  logic [NARROW_W-1:0] narrow_i,
  input  logic [MID_W-1:0]    mid_i,
  input  logic [OP_W-1:0]     full_i,
  input  shr_ctrl_t           ctrl_i,
  output logic [OP_W-1:0]     result_o
);

  logic [OP_W-1:0] picked;

  always_comb begin
    unique case (ctrl_i.lane)
      LANE_8:  picked = {{(OP_W-NARROW_W){ctrl_i.is_signed & narrow_i[NARROW_W-1]}}, narrow_i};
      LANE_16: picked = {{(OP_W-MID_W){ctrl_i.is_signed & mid_i[MID_W-1]}}, mid_i};
      LANE_32: picked = full_i;
      default: picked = '0;
    endcase
    result_o = ctrl_i.range_err ? '0 : picked;
  end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shr_pkg::*;
#(
  parameter int unsigned OP_W  = 32,
  localparam int unsigned CNT_W    = $clog2(OP_W) + 1,
  localparam int unsigned NARROW_W = OP_W / 4,
  localparam int unsigned MID_W    = OP_W / 2
) (
  input  logic [OP_W-1:0]  operand_i,
  input  logic [2:0]       dtype_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             rotate_i,
  output logic [OP_W-1:0]  result_o,
  output logic             range_err_o
);

  shr_ctrl_t ctrl;

  logic [NARROW_W-1:0] narrow_res;
  logic [MID_W-1:0]    mid_res;
  logic [OP_W-1:0]     full_res;

  shr_decode #(.OP_W(OP_W), .CNT_W(CNT_W)) u_decode (
    .dtype_i (dtype_i),
    .count_i (count_i),
    .ctrl_o  (ctrl)
  );

  shr_lane #(.LANE_W(NARROW_W)) u_lane_narrow (
    .lane_i      (operand_i[NARROW_W-1:0]),
    .amt_i       (ctrl.magnitude[$clog2(NARROW_W)-1:0]),
    .to_left_i   (ctrl.to_left),
    .rotate_i    (rotate_i),
    .is_signed_i (ctrl.is_signed),
    .lane_o      (narrow_res)
  );

  shr_lane #(.LANE_W(MID_W)) u_lane_mid (
    .lane_i      (operand_i[MID_W-1:0]),
    .amt_i       (ctrl.magnitude[$clog2(MID_W)-1:0]),
    .to_left_i   (ctrl.to_left),
    .rotate_i    (rotate_i),
    .is_signed_i (ctrl.is_signed),
    .lane_o      (mid_res)
  );

  shr_lane #(.LANE_W(OP_W)) u_lane_full (
    .lane_i      (operand_i),
    .amt_i       (ctrl.magnitude[$clog2(OP_W)-1:0]),
    .to_left_i   (ctrl.to_left),
    .rotate_i    (rotate_i),
    .is_signed_i (ctrl.is_signed),
    .lane_o      (full_res)
  );

  shr_extend #(.OP_W(OP_W)) u_extend (
    .narrow_i (narrow_res),
    .mid_i    (mid_res),
    .full_i   (full_res),
    .ctrl_i   (ctrl),
    .result_o (result_o)
  );

  assign range_err_o = ctrl.range_err;

endmodule

// File: rtl/shr_checker.sv
module shr_checker #(
  parameter int unsigned OP_W  = 32,
  localparam int unsigned CNT_W = $clog2(OP_W) + 1
) (
  input logic [OP_W-1:0]  operand_i,
  input logic [2:0]       dtype_i,
  input logic [CNT_W-1:0] count_i,
  input logic             rotate_i,
  input logic [OP_W-1:0]  result_o,
  input logic             range_err_o
);

  localparam int unsigned NW = OP_W / 4;

  int unsigned mag;
  logic [OP_W-1:0] low_mask;

  always_comb begin
    mag = count_i[CNT_W-1] ? int'((~count_i) + 1'b1) : int'(count_i);
    low_mask = (mag >= OP_W) ? '1 : ((OP_W'(1) << mag) - 1'b1);

    // R9
    err_zero_chk: assert (!range_err_o || (result_o == '0));

    // R9
    narrow_ok_chk: assert (!((dtype_i[1:0] == 2'd0) && (mag < NW)) || !range_err_o);

    // R6
    zero_count_chk: assert (!((count_i == '0) && (dtype_i[1:0] == 2'd2)) || (result_o == operand_i));

    // R5
    rot_pop_chk: assert (!(rotate_i && (dtype_i[1:0] == 2'd2) && !range_err_o)
                         || ($countones(result_o) == $countones(operand_i)));

    // R2
    left_fill_chk: assert (!(!rotate_i && !count_i[CNT_W-1] && (dtype_i[1:0] == 2'd2) && !range_err_o)
                           || ((result_o & low_mask) == '0));

    // R8
    narrow_ext_chk: assert (!((dtype_i[1:0] == 2'd0) && !range_err_o)
                            || (result_o[OP_W-1:NW] == {(OP_W-NW){dtype_i[2] & result_o[NW-1]}}));
  end

endmodule

bind shift_rotate_unit shr_checker #(.OP_W(OP_W)) u_shr_checker (
  .operand_i   (operand_i),
  .dtype_i     (dtype_i),
  .count_i     (count_i),
  .rotate_i    (rotate_i),
  .result_o    (result_o),
  .range_err_o (range_err_o)
);

// File: tb/tb_shift_rotate_unit.sv
`timescale 1ns/1ps
module tb_shift_rotate_unit;

  logic        clk;
  logic        rst_n;
  logic [31:0] operand_i;
  logic [2:0]  dtype_i;
  logic [5:0]  count_i;
  logic        rotate_i;
  logic [31:0] result_o;
  logic        range_err_o;

  int checks;
  int errors;

  shift_rotate_unit dut (
    .operand_i   (operand_i),
    .dtype_i     (dtype_i),
    .count_i     (count_i),
    .rotate_i    (rotate_i),
    .result_o    (result_o),
    .range_err_o (range_err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [32:0] model(input logic [31:0] op, input logic [2:0] dt,
                                        input logic [5:0] cnt, input logic rot);
    int w;
    int c;
    int m;
    logic [31:0] mask;
    logic [31:0] v;
    logic edge_bit;
    case (dt[1:0])
      2'd0: w = 8;
      2'd1: w = 16;
      2'd2: w = 32;
      default: w = 0;
    endcase
    c = cnt[5] ? int'(cnt) - 64 : int'(cnt);
    m = (c < 0) ? -c : c;
    if (w == 0 || m >= w) return {1'b1, 32'h0};
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    v = op & mask;
    for (int i = 0; i < m; i++) begin
      if (c > 0) begin
        edge_bit = v[w-1];
        v = (v << 1) & mask;
        if (rot) v[0] = edge_bit;
      end else begin
        edge_bit = rot ? v[0] : (dt[2] & v[w-1]);
        v = v >> 1;
        v[w-1] = edge_bit;
      end
    end
    if (dt[2] && v[w-1]) v = v | ~mask;
    return {1'b0, v};
  endfunction

  task automatic apply_check(input string tag, input logic [31:0] op, input logic [2:0] dt,
                             input logic [5:0] cnt, input logic rot);
    logic [32:0] exp;
    @(posedge clk);
    #2;
    operand_i = op;
    dtype_i   = dt;
    count_i   = cnt;
    rotate_i  = rot;
    exp = model(op, dt, cnt, rot);
    @(negedge clk);
    checks++;
    if ({range_err_o, result_o} !== exp) begin
      errors++;
      $display("FAIL %s: op=%h dt=%b cnt=%0d rot=%b actual err=%b res=%h expected err=%b res=%h",
               tag, op, dt, $signed(cnt), rot, range_err_o, result_o, exp[32], exp[31:0]);
    end
  endtask

  task automatic fixed_check(input string tag, input logic [31:0] op, input logic [2:0] dt,
                             input logic [5:0] cnt, input logic rot,
                             input logic exp_err, input logic [31:0] exp_res);
    @(posedge clk);
    #2;
    operand_i = op;
    dtype_i   = dt;
    count_i   = cnt;
    rotate_i  = rot;
    @(negedge clk);
    checks++;
    if (range_err_o !== exp_err || result_o !== exp_res) begin
      errors++;
      $display("FAIL %s: actual err=%b res=%h expected err=%b res=%h",
               tag, range_err_o, result_o, exp_err, exp_res);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    operand_i = 32'h0;
    dtype_i = 3'b010;
    count_i = 6'd0;
    rotate_i = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    @(negedge clk);
    checks++;
    if (result_o !== 32'h0 || range_err_o !== 1'b0) begin
      errors++;
      $display("FAIL R6 idle: actual err=%b res=%h expected err=0 res=00000000", range_err_o, result_o);
    end

    fixed_check("R3 signed right",     32'h8000_00F0, 3'b110, -6'sd4, 1'b0, 1'b0, 32'hF800_000F);
    fixed_check("R4 unsigned right",   32'h8000_00F0, 3'b010, -6'sd4, 1'b0, 1'b0, 32'h0800_000F);
    fixed_check("R2 left discard",     32'h8000_00F0, 3'b010,  6'sd4, 1'b0, 1'b0, 32'h0000_0F00);
    fixed_check("R5 rotate right",     32'h8000_00F0, 3'b010, -6'sd4, 1'b1, 1'b0, 32'h0800_000F);
    fixed_check("R5 rotate left",      32'h8000_00F0, 3'b010,  6'sd4, 1'b1, 1'b0, 32'h0000_0F08);
    fixed_check("R1 direction left",   32'h0000_0001, 3'b010,  6'sd31, 1'b0, 1'b0, 32'h8000_0000);
    fixed_check("R7 R8 narrow signed", 32'h1234_5681, 3'b100, -6'sd1, 1'b0, 1'b0, 32'hFFFF_FFC0);
    fixed_check("R7 narrow rotate",    32'h1234_5681, 3'b000,  6'sd1, 1'b1, 1'b0, 32'h0000_0003);
    fixed_check("R8 mid signed",       32'hABCD_4000, 3'b101,  6'sd1, 1'b0, 1'b0, 32'hFFFF_8000);
    fixed_check("R6 zero mid",         32'hDEAD_BEEF, 3'b001,  6'sd0, 1'b0, 1'b0, 32'h0000_BEEF);
    fixed_check("R6 zero full rot",    32'hDEAD_BEEF, 3'b010,  6'sd0, 1'b1, 1'b0, 32'hDEAD_BEEF);
    fixed_check("R9 narrow +8",        32'hFFFF_FFFF, 3'b000,  6'sd8, 1'b0, 1'b1, 32'h0);
    fixed_check("R9 narrow -8",        32'hFFFF_FFFF, 3'b100, -6'sd8, 1'b1, 1'b1, 32'h0);
    fixed_check("R9 narrow +7",        32'h0000_0001, 3'b000,  6'sd7, 1'b0, 1'b0, 32'h0000_0080);
    fixed_check("R9 mid -16",          32'h0000_8000, 3'b001, -6'sd16, 1'b0, 1'b1, 32'h0);
    fixed_check("R9 full -32",         32'h8000_0000, 3'b110, -6'sd32, 1'b0, 1'b1, 32'h0);
    fixed_check("R9 full -31",         32'h8000_0000, 3'b110, -6'sd31, 1'b0, 1'b0, 32'hFFFF_FFFF);
    fixed_check("R7 bad width",        32'h1234_5678, 3'b011,  6'sd1, 1'b0, 1'b1, 32'h0);

    // R10: a later input change alone moves the output within the same cycle
    fixed_check("R10 follow a",        32'h0000_0003, 3'b010,  6'sd1, 1'b0, 1'b0, 32'h0000_0006);
    #1;
    operand_i = 32'h0000_0005;
    #1;
    checks++;
    if (result_o !== 32'h0000_000A) begin
      errors++;
      $display("FAIL R10 follow b: actual %h expected 0000000a", result_o);
    end

    for (int n = 0; n < 3000; n++) begin
      logic [2:0] dt;
      logic [5:0] cnt;
      int w;
      dt = 3'($urandom());
      if (dt[1:0] == 2'd3 && ($urandom() % 4) != 0) dt[1:0] = 2'd2;
      cnt = 6'($urandom());
      if ((n % 4) == 0) begin
        w = (dt[1:0] == 2'd0) ? 8 : (dt[1:0] == 2'd1) ? 16 : 32;
        cnt = 6'(w - 1 + int'($urandom() % 2));
        if ($urandom() % 2) cnt = 6'(-int'(cnt));
      end
      apply_check("R1 R2 R3 R4 R5 R8 R9 random", $urandom(), dt, cnt, 1'($urandom()));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule